// File: doc/BRIEF.md
# Store Buffer with Typed Memory Fences

This block sits between a simple in-order core and a single-ported memory and keeps a small queue of stores that have been accepted from the core but not yet written to memory. Stores drain to memory one at a time, oldest first. A load whose address matches no queued store is sent to memory ahead of the queued stores, so the only ordering that is relaxed is an older write followed by a younger read. A load whose address matches a queued store never goes to memory. It takes its data from the youngest matching entry in the same cycle it is presented.

The core issues one operation at a time over a valid/ready handshake. The operation is a load, a store or a fence, and the fence carries one of four types. A load handshake completes when its data is on `ldData`, so read-to-read and read-to-write order hold because the core is in order. The write-then-read fence is the only fence that waits: it completes once the queue has drained. The other three fences complete in the cycle they are presented, because in-order loads and in-order store draining already give the orderings they name.

The memory side offers one request at a time with valid/ready. A read then waits for a one-cycle data return. While a read is outstanding, no other request is offered. Once a write request has been offered, it stays offered and unchanged until memory accepts it.

Top module: `tsoStoreBuffer`

## Requirements
- R1: After reset the queue is empty and no memory request is offered. A write-then-read fence then completes at once, and a load that hits nothing is offered to memory at once.
- R2: A store is accepted while fewer than DEPTH (4) entries are queued. While the queue is full, `reqReady` is low for a store.
- R3: Queued stores are written to memory strictly in acceptance order, one entry per accepted write request, with that entry's address and data. A write is offered whenever the queue is non-empty and no read takes precedence.
- R4: When a load that matches no queued entry is presented and no write offer is held, a read to the load's address is offered in that cycle, ahead of any queued store.
- R5: A load whose address matches a queued entry completes in the cycle it is presented, returns the data of the youngest matching entry, and causes no memory read.
- R6: A load that misses completes in the cycle `memRvalid` is high, returning `memRdata`. No memory request is offered between acceptance of the read and its return.
- R7: Operation codes on `reqKind` are 00 load, 01 store and 10 fence. Fence codes on `reqFence` are 00 read-read, 01 write-read, 10 read-write and 11 write-write.
- R8: A write-read fence completes only in a cycle in which the queue is empty. Stores keep draining while it waits.
- R9: Read-read, read-write and write-write fences complete in the cycle they are presented. Stores accepted after a write-write fence still drain after those accepted before it, and later loads proceed past it.
- R10: A write request that is offered but not accepted stays offered next cycle with the same address and data.
- R11: Reset while a read is outstanding drops that read. The block comes out of reset idle, with an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core operation valid |
| reqReady | output | 1 | Core operation completes this cycle |
| reqKind | input | 2 | Operation code (R7) |
| reqFence | input | 2 | Fence type when the operation is a fence (R7) |
| reqAddr | input | ADDR_W | Load or store address |
| reqWdata | input | DATA_W | Store data |
| ldData | output | DATA_W | Load result, valid at a load handshake |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts the request |
| memWrite | output | 1 | Request is a write (1) or a read (0) |
| memAddr | output | ADDR_W | Request address |
| memWdata | output | DATA_W | Write data |
| memRvalid | input | 1 | Read data return strobe |
| memRdata | input | DATA_W | Read data |

## Verification
Every result of this block is combinational on its registered state. `reqReady`, `ldData` and the memory request are therefore due in the same cycle as the inputs that cause them. An entry leaves the queue at the clock edge where its write is accepted, and it is gone in the following cycle. A read accepted at an edge makes the block wait from the next cycle until the cycle in which `memRvalid` is high. The bench drives inputs just after the rising edge and compares all outputs against its queue model at the falling edge. It then advances the model by the handshakes that the coming rising edge will complete, so every comparison falls in the cycle its result is due.

// File: rtl/tsoBufPkg.sv
package tsoBufPkg;

  // Operation code on the core port
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_FENCE = 2'b10,
    OP_RSVD  = 2'b11
  } opKind_e;

  // Fence type: first letter is the older access, second the younger one
  typedef enum logic [1:0] {
    FN_RR = 2'b00,
    FN_WR = 2'b01,
    FN_RW = 2'b10,
    FN_WW = 2'b11
  } fenceKind_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_LDWAIT = 1'b1
  } ctlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;      // enqueue the core's store
    logic pop;       // head entry accepted by memory
    logic selWrite;  // memory address comes from the head entry
    logic fromMem;   // load result comes from memory read data
  } bufStrobe_t;

endpackage

// File: rtl/storeBufDatapath.sv
module storeBufDatapath
  import tsoBufPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4   // power of two, at least 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              bufFull,
  output logic              bufEmpty,
  output logic              bufHit,
  output logic [DATA_W-1:0] ldData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [PTR_W-1:0]  headPtr, tailPtr;
  logic [CNT_W-1:0]  count;

  logic [DEPTH-1:0]  matchVec;
  logic [DATA_W-1:0] slotData [DEPTH];
  logic [DATA_W-1:0] fwdData;

  assign bufFull  = (count == CNT_W'(DEPTH));
  assign bufEmpty = (count == '0);

  // Storage, no reset needed: occupancy is tracked by the pointers
  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrMem[tailPtr] <= inAddr;
      dataMem[tailPtr] <= inData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strobe.push) tailPtr <= tailPtr + 1'b1;
      if (strobe.pop)  headPtr <= headPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // One comparator per slot, slots numbered by age (0 = oldest)
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [PTR_W-1:0] slotIdx;
    assign slotIdx     = headPtr + PTR_W'(g);
    assign matchVec[g] = (CNT_W'(g) < count) && (addrMem[slotIdx] == inAddr);
    assign slotData[g] = dataMem[slotIdx];
  end

  // Youngest match wins: later slots overwrite earlier ones
  always_comb begin
    fwdData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (matchVec[i]) fwdData = slotData[i];
    end
  end

  assign bufHit   = |matchVec;
  assign ldData   = strobe.fromMem ? memRdata : fwdData;
  assign memAddr  = strobe.selWrite ? addrMem[headPtr] : inAddr;
  assign memWdata = dataMem[headPtr];

  // R2: control never enqueues into a full queue
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push && !strobe.pop |-> count < CNT_W'(DEPTH));

  // R3: memory only accepts a write while an entry is held
  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> count != '0);

endmodule

// File: rtl/storeBufControl.sv
module storeBufControl
  import tsoBufPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic [1:0] reqFence,
  input  logic       memReady,
  input  logic       memRvalid,
  input  logic       bufFull,
  input  logic       bufEmpty,
  input  logic       bufHit,
  output logic       reqReady,
  output logic       memValid,
  output logic       memWrite,
  output bufStrobe_t strobe
);

  ctlState_e state;
  logic wrLock;      // a write offer is pending and must be held
  logic isLoad, isStore, isFence;
  logic loadMiss, issueRead, issueWrite;

  assign isLoad  = (reqKind == OP_LOAD);
  assign isStore = (reqKind == OP_STORE);
  assign isFence = (reqKind == OP_FENCE);

  always_comb begin
    loadMiss   = (state == ST_IDLE) && reqValid && isLoad && !bufHit;
    issueRead  = loadMiss && !wrLock;
    issueWrite = (state == ST_IDLE) && !issueRead && !bufEmpty;
    memValid   = issueRead || issueWrite;
    memWrite   = issueWrite;

    reqReady = 1'b0;
    if (state == ST_LDWAIT)  reqReady = isLoad && memRvalid;
    else if (isLoad)         reqReady = bufHit;
    else if (isStore)        reqReady = !bufFull;
    else if (isFence)        reqReady = (reqFence == FN_WR) ? bufEmpty : 1'b1;

    strobe.push     = reqValid && isStore && reqReady;
    strobe.pop      = issueWrite && memReady;
    strobe.selWrite = issueWrite;
    strobe.fromMem  = (state == ST_LDWAIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      wrLock <= 1'b0;
    end else begin
      wrLock <= issueWrite && !memReady;
      case (state)
        ST_IDLE:   if (issueRead && memReady) state <= ST_LDWAIT;
        ST_LDWAIT: if (memRvalid)             state <= ST_IDLE;
        default:                              state <= ST_IDLE;
      endcase
    end
  end

  // R6: nothing else goes to memory while a read is outstanding
  assert_one_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_LDWAIT |-> !memValid);

  // R5: a forwarded load never reaches memory
  assert_fwd_no_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && isLoad && bufHit) |-> !(memValid && !memWrite));

  // R8: a write-read fence only completes with nothing left to write
  assert_fence_drained_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && isFence && reqFence == FN_WR && reqReady) |-> !memWrite);

endmodule

// File: rtl/tsoStoreBuffer.sv
module tsoStoreBuffer
  import tsoBufPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqFence,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] ldData,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata
);

  bufStrobe_t strobe;
  logic bufFull, bufEmpty, bufHit;

  storeBufControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqFence (reqFence),
    .memReady (memReady),
    .memRvalid(memRvalid),
    .bufFull  (bufFull),
    .bufEmpty (bufEmpty),
    .bufHit   (bufHit),
    .reqReady (reqReady),
    .memValid (memValid),
    .memWrite (memWrite),
    .strobe   (strobe)
  );

  storeBufDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inAddr  (reqAddr),
    .inData  (reqWdata),
    .memRdata(memRdata),
    .bufFull (bufFull),
    .bufEmpty(bufEmpty),
    .bufHit  (bufHit),
    .ldData  (ldData),
    .memAddr (memAddr),
    .memWdata(memWdata)
  );

  // R10: an unaccepted write offer is held unchanged
  assert_write_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memWrite && !memReady |=>
      memValid && memWrite && $stable(memAddr) && $stable(memWdata));

endmodule

// File: tb/tsoStoreBuffer_test.sv
`timescale 1ns/1ps
module tsoStoreBuffer_test;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'b00;
  logic [1:0]  reqFence = 2'b00;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        memReady = 1'b0;
  logic        memRvalid = 1'b0;
  logic [31:0] memRdata = '0;
  logic        reqReady, memValid, memWrite;
  logic [15:0] memAddr;
  logic [31:0] memWdata, ldData;

  always #10 clk = ~clk;  // 50 MHz

  tsoStoreBuffer uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqKind(reqKind),
    .reqFence(reqFence), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .ldData(ldData),
    .memValid(memValid), .memReady(memReady), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata),
    .memRvalid(memRvalid), .memRdata(memRdata)
  );

  int nCmp = 0;
  int nBad = 0;
  int cyc = 0;
  int sinceRst = 0;
  int readyPct = 100;
  int latency = 2;

  // Reference model state
  logic [15:0] qA[$];
  logic [31:0] qD[$];
  logic [31:0] arch [256];
  bit waiting = 0;
  bit lockM = 0;

  // Handshake flags handed from the model to the memory driver
  bit rdAccFlag = 0, wrAccFlag = 0;
  logic [15:0] rdAddrF = '0, wAddrF = '0;
  logic [31:0] wDataF = '0;

  function automatic logic [31:0] initVal(input int i);
    return 32'h5A000000 ^ (32'(i) * 32'h00010101);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string what);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Model: compare at the falling edge, then advance by the coming edge
  always @(negedge clk) begin
    bit mHit, isL, isS, isF, eRead, eWrite, eReady;
    logic [31:0] mFwd;
    string tag;
    if (cyc == 0) for (int i = 0; i < 256; i++) arch[i] = initVal(i);
    cyc++;
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
    rdAccFlag = 0;
    wrAccFlag = 0;
    if (!rstN) begin
      qA.delete(); qD.delete();
      waiting = 0; lockM = 0; sinceRst = 0;
    end else begin
      sinceRst++;
      mHit = 0; mFwd = '0;
      for (int i = 0; i < qA.size(); i++)
        if (qA[i] == reqAddr) begin mHit = 1; mFwd = qD[i]; end
      isL = reqValid && reqKind == 2'b00;
      isS = reqValid && reqKind == 2'b01;
      isF = reqValid && reqKind == 2'b10;
      eRead  = !waiting && isL && !mHit && !lockM;
      eWrite = !waiting && !eRead && qA.size() > 0;

      if (sinceRst <= 2)  tag = "R1,R11";
      else if (lockM)     tag = "R10";
      else if (waiting)   tag = "R6";
      else if (eRead)     tag = "R4";
      else                tag = "R3";
      chk(32'(memValid), 32'(eRead || eWrite), tag, "memValid");
      if (eRead || eWrite) chk(32'(memWrite), 32'(eWrite), tag, "memWrite");
      if (eRead) chk(32'(memAddr), 32'(reqAddr), tag, "read address");
      if (eWrite) begin
        chk(32'(memAddr), 32'(qA[0]), tag, "write address");
        chk(memWdata, qD[0], tag, "write data");
      end

      if (reqValid) begin
        if (waiting)  begin eReady = isL && memRvalid; tag = "R6"; end
        else if (isL) begin eReady = mHit; tag = "R5"; end
        else if (isS) begin eReady = qA.size() < DEPTH; tag = "R2"; end
        else if (isF && reqFence == 2'b01) begin eReady = qA.size() == 0; tag = "R8 R7"; end
        else if (isF) begin eReady = 1; tag = "R9"; end
        else begin eReady = 0; tag = "R7"; end
        chk(32'(reqReady), 32'(eReady), tag, "reqReady");
        if (isL && reqReady) begin
          chk(ldData, arch[reqAddr[7:0]], waiting ? "R6" : "R5", "load data");
          if (!waiting) chk(mFwd, arch[reqAddr[7:0]], "R5", "youngest entry");
        end
      end

      // Advance model by the coming rising edge
      if (memValid && memReady) begin
        if (memWrite) begin wrAccFlag = 1; wAddrF = memAddr; wDataF = memWdata; end
        else begin rdAccFlag = 1; rdAddrF = memAddr; end
      end
      if (eWrite && memReady) begin void'(qA.pop_front()); void'(qD.pop_front()); end
      lockM = eWrite && !memReady;
      if (waiting && memRvalid) waiting = 0;
      else if (eRead && memReady) waiting = 1;
      if (isS && reqReady) begin
        qA.push_back(reqAddr); qD.push_back(reqWdata);
        arch[reqAddr[7:0]] = reqWdata;
      end
    end
  end

  // Memory model, driven after the edge
  logic [31:0] memArr [256];
  bit memInit = 0;
  int rdTimer = 0;
  always @(posedge clk) begin
    #2;
    if (!memInit) begin
      for (int i = 0; i < 256; i++) memArr[i] = initVal(i);
      memInit = 1;
    end
    if (!rstN) begin
      rdTimer = 0; memRvalid = 0; memReady = 0;
    end else begin
      if (wrAccFlag) memArr[wAddrF[7:0]] = wDataF;
      memRvalid = 0;
      if (rdTimer > 0) begin
        rdTimer--;
        if (rdTimer == 0) begin memRvalid = 1; memRdata = memArr[rdAddrF[7:0]]; end
      end
      if (rdAccFlag) begin
        if (latency <= 1) begin memRvalid = 1; memRdata = memArr[rdAddrF[7:0]]; end
        else rdTimer = latency - 1;
      end
      memReady = ($urandom_range(0, 99) < readyPct);
    end
  end

  task automatic op(input logic [1:0] k, input logic [1:0] f,
                    input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reqValid = 1; reqKind = k; reqFence = f; reqAddr = a; reqWdata = d;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  task automatic st(input logic [15:0] a, input logic [31:0] d); op(2'b01, 2'b00, a, d); endtask
  task automatic ld(input logic [15:0] a); op(2'b00, 2'b00, a, '0); endtask
  task automatic fn(input logic [1:0] f); op(2'b10, f, '0, '0); endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    repeat (2) @(posedge clk);

    // R1: fresh block drains nothing, wr fence and miss go at once
    fn(2'b01);
    ld(16'd40);

    // R2, R5: fill while memory stalls, forward youngest
    readyPct = 0;
    st(16'd1, 32'h11111111);
    st(16'd2, 32'h22222222);
    st(16'd3, 32'h33333333);
    st(16'd2, 32'h2222BBBB);
    ld(16'd2);
    ld(16'd1);
    fork
      st(16'd4, 32'h44444444);
      begin repeat (6) @(posedge clk); readyPct = 100; end
    join
    fn(2'b01);

    // R4: miss overtakes queued stores
    readyPct = 0;
    st(16'd9, 32'h99999999);
    st(16'd10, 32'hAAAAAAAA);
    readyPct = 100;
    ld(16'd50);
    fn(2'b01);

    // R9: non-waiting fences, ww between stores
    readyPct = 30;
    fn(2'b00);
    fn(2'b10);
    st(16'd11, 32'hB0B0B0B0);
    fn(2'b11);
    st(16'd12, 32'hC0C0C0C0);
    ld(16'd11);
    ld(16'd60);
    fn(2'b01);

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      int r;
      readyPct = $urandom_range(20, 100);
      latency  = $urandom_range(1, 3);
      r = $urandom_range(0, 9);
      if (r < 4)      st(16'($urandom_range(0, 15)), $urandom);
      else if (r < 8) ld(16'($urandom_range(0, 15)));
      else            fn(2'($urandom_range(0, 3)));
    end

    // R11: reset while a read is outstanding
    readyPct = 100;
    latency = 3;
    fn(2'b01);
    @(posedge clk); #1;
    reqValid = 1; reqKind = 2'b00; reqAddr = 16'd200;
    @(negedge clk);
    while (!(memValid && memReady)) @(negedge clk);
    @(posedge clk); #1;
    reqValid = 0;
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    repeat (4) @(posedge clk);
    ld(16'd7);
    st(16'd7, 32'h77777777);
    ld(16'd7);
    fn(2'b01);

    repeat (5) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule